// File: doc/BRIEF.md
# Colour-Transform Coefficient Write Sequencer

This block turns a 3x4 colour-transform matrix into the twelve register writes that program a per-plane colour-space-conversion unit. Software, or an upstream agent, loads twelve 64-bit entries through a simple indexed load port. Each entry is sign-magnitude: a sign bit on top and a magnitude with 32 fractional bits below it. In each row of four entries, the first three are matrix coefficients and the fourth is that row's post-offset.

A start pulse launches the sequence. Each coefficient is encoded into a 16-bit word made of a sign, a 3-bit range code and a rounded 9-bit mantissa. Coefficients are packed into six registers. Three pre-offset registers are then cleared. Last, each post-offset is converted to a 13-bit two's-complement fraction and written. Writes leave over a valid/ready port that holds address and data steady until accepted. A one-cycle done pulse marks the end. The sequence is not started when the target plane cannot take a matrix, or when no complete matrix has been loaded.

Top module: `csc_coef_seq`

## Requirements
- R1: An entry's magnitude is its value with bit 63 cleared. Magnitudes of 4.0 (0x4_0000_0000) or more are clamped to 0x3_FFFF_FFFF before encoding, so they encode as range code 6 with mantissa 511.
- R2: The coefficient range code sits in bits 14:12 and is chosen by magnitude m. Fractional precision f applies as follows: m<0.125 gives code 3 and f=12; m<0.25 gives code 2 and f=11; m<0.5 gives code 1 and f=10; m<1.0 gives code 0 and f=9; m<2.0 gives code 7 and f=8; otherwise code 6 and f=7.
- R3: The mantissa sits in bits 11:3 and equals round-half-up(m·2^f). It saturates at 511. Bits 2:0 are zero. Bit 15 copies entry bit 63, including for a magnitude of zero.
- R4: Write k (k=0..5) goes to COEF_BASE+4k. Row r=k/2 uses entries 4r, 4r+1 and 4r+2. Even k carries {enc(4r), enc(4r+1)} as bits 31:16 and 15:0. Odd k carries {enc(4r+2), 16'h0}.
- R5: Writes 6..8 go to PRE_BASE, PRE_BASE+4 and PRE_BASE+8, each with data zero.
- R6: Writes 9..11 go to POST_BASE+4p (p=0..2), taking entry 4p+3. The data is floor(m·2^12), saturated at 4095, negated in 13-bit two's complement when bit 63 is set. The result sits in bits 12:0, and bits 31:13 are zero.
- R7: A start produces no write and no done when plane_ok is low, or when any of the twelve entries has not been loaded since reset.
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data stay unchanged on the next cycle.
- R9: done is high for exactly the one cycle after the twelfth accepted write. Start pulses and loads that arrive while a sequence runs are ignored.
- R10: After reset, wr_valid, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plane_ok | input | 1 | Target plane accepts a transform matrix |
| ld_valid | input | 1 | Load strobe for one matrix entry |
| ld_idx | input | 4 | Entry index 0..11 |
| ld_data | input | 64 | Sign-magnitude entry, 32 fractional bits |
| start | input | 1 | Launch the write sequence |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Receiver accepts the pending write |
| wr_addr | output | ADDR_W (12) | Register address |
| wr_data | output | 32 | Register data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench uses the default parameters: 12-bit addresses with the coefficient, pre-offset and post-offset banks at 0x100, 0x120 and 0x130. This keeps the three banks apart, so a write that lands in the wrong bank shows up directly in the address comparison. The matrices loaded place coefficients exactly on every range boundary, and one value rounds past the top of its mantissa. They also include a negative zero, a clamped magnitude and post-offsets beyond the representable fraction. Random back-pressure on wr_ready exercises the hold rule, while a back-to-back run exercises the full-rate path.

// File: rtl/csc_seq_pkg.sv
// Package: shared widths and constants for the coefficient write sequencer.
// Assumes entries are 64-bit sign-magnitude values with 32 fractional bits.
package csc_seq_pkg;
    localparam int ENTRY_W  = 64;
    localparam int N_ENTRY  = 12;
    localparam int N_WRITES = 12;
    localparam int DATA_W   = 32;
    localparam int COEF_W   = 16;
    localparam int MANT_W   = 9;
    localparam int POFF_W   = 13;
    localparam int IDX_W    = 4;
    localparam int MAG_W    = 34;   // magnitude after clamping below 4.0

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [COEF_W-1:0]  coef_t;
    typedef logic [POFF_W-1:0]  poff_t;
endpackage

// File: rtl/csc_entry_store.sv
// Module: holds the twelve matrix entries and tracks which were loaded.
// Assumes the caller gates ld_en while a sequence is running.
module csc_entry_store
    import csc_seq_pkg::*;
#(
    parameter int N = N_ENTRY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  entry_t            ld_data,
    output entry_t [N-1:0]    entries,
    output logic              all_loaded
);
    logic [N-1:0] loaded_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Capture one entry and remember it has been written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g]  <= '0;
                loaded_q[g] <= 1'b0;
            end else if (ld_en && (ld_idx == IDX_W'(g))) begin
                entries[g]  <= ld_data;
                loaded_q[g] <= 1'b1;
            end
        end
    end

    assign all_loaded = &loaded_q;
endmodule

// File: rtl/csc_coef_enc.sv
// Module: encodes one sign-magnitude entry into a 16-bit coefficient word
// {sign, range code[2:0], mantissa[8:0], 3'b000}. Purely combinational.
module csc_coef_enc
    import csc_seq_pkg::*;
(
    input  entry_t ent,
    output coef_t  code_word
);
    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

    logic [MAG_W-1:0]  mag;
    logic [2:0]        rcode;
    logic [4:0]        shamt;
    logic [MAG_W:0]    rounded;
    logic [MAG_W:0]    shifted;
    logic [MANT_W-1:0] mant;

    // Clamp, pick range by magnitude, then round and saturate the mantissa.
    always_comb begin
        mag = (ent[62:MAG_W] != '0) ? MAG_MAX : ent[MAG_W-1:0];
        if (mag < 34'h0_2000_0000) begin
            rcode = 3'd3; shamt = 5'd20;
        end else if (mag < 34'h0_4000_0000) begin
            rcode = 3'd2; shamt = 5'd21;
        end else if (mag < 34'h0_8000_0000) begin
            rcode = 3'd1; shamt = 5'd22;
        end else if (mag < 34'h1_0000_0000) begin
            rcode = 3'd0; shamt = 5'd23;
        end else if (mag < 34'h2_0000_0000) begin
            rcode = 3'd7; shamt = 5'd24;
        end else begin
            rcode = 3'd6; shamt = 5'd25;
        end
        rounded = {1'b0, mag} + ((MAG_W+1)'(1) << (shamt - 5'd1));
        shifted = rounded >> shamt;
        mant    = (shifted > (MAG_W+1)'(2**MANT_W - 1)) ? {MANT_W{1'b1}}
                                                        : shifted[MANT_W-1:0];
        code_word = {ent[63], rcode, mant, 3'b000};
    end
endmodule

// File: rtl/csc_poff_enc.sv
// Module: converts a sign-magnitude entry into a 13-bit two's-complement
// fraction with 12 fractional bits (truncating, saturating). Combinational.
module csc_poff_enc
    import csc_seq_pkg::*;
(
    input  entry_t ent,
    output poff_t  offset
);
    logic [POFF_W-2:0] mag12;

    // Truncate to 12 fractional bits, saturate, then apply the sign.
    always_comb begin
        mag12  = (ent[62:32] != '0) ? {(POFF_W-1){1'b1}} : ent[31:20];
        offset = ent[63] ? (poff_t'(0) - {1'b0, mag12}) : {1'b0, mag12};
    end
endmodule

// File: rtl/csc_coef_seq.sv
// Module: top of the sequencer. On start it walks twelve register writes
// (six coefficient, three zero pre-offset, three post-offset) over a
// valid/ready port and pulses done after the last one.
// Assumes the receiver eventually raises wr_ready; loads and starts
// arriving while busy are dropped.
module csc_coef_seq
    import csc_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] COEF_BASE = 12'h100,
    parameter logic [ADDR_W-1:0] PRE_BASE  = 12'h120,
    parameter logic [ADDR_W-1:0] POST_BASE = 12'h130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plane_ok,
    input  logic              ld_valid,
    input  logic [3:0]        ld_idx,
    input  logic [63:0]       ld_data,
    input  logic              start,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_WRITES - 1);
    localparam logic [IDX_W-1:0] PRE_FIRST = IDX_W'(6);
    localparam logic [IDX_W-1:0] PST_FIRST = IDX_W'(9);

    entry_t [N_ENTRY-1:0] entries;
    logic                 all_loaded;
    logic [IDX_W-1:0]     idx_q;
    logic                 busy_q, done_q;
    logic [IDX_W-1:0]     sel_a, sel_b, sel_p;
    logic [IDX_W-1:0]     row, post_row;
    coef_t                enc_a, enc_b;
    poff_t                poff;

    csc_entry_store #(.N(N_ENTRY)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_valid && !busy_q), .ld_idx(ld_idx), .ld_data(ld_data),
        .entries(entries), .all_loaded(all_loaded)
    );

    csc_coef_enc u_enc_a (.ent(entries[sel_a]), .code_word(enc_a));
    csc_coef_enc u_enc_b (.ent(entries[sel_b]), .code_word(enc_b));
    csc_poff_enc u_poff  (.ent(entries[sel_p]), .offset(poff));

    // Sequence control: launch, step on each accepted write, flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start && plane_ok && all_loaded) begin
                    busy_q <= 1'b1;
                    idx_q  <= '0;
                end
            end else if (wr_ready) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Entry selection for the current write index.
    always_comb begin
        row      = idx_q >> 1;
        post_row = (idx_q >= PST_FIRST) ? idx_q - PST_FIRST : '0;
        sel_a    = (row << 2) + (idx_q[0] ? IDX_W'(2) : IDX_W'(0));
        sel_b    = (row << 2) + IDX_W'(1);
        if (idx_q >= PRE_FIRST) begin
            sel_a = '0;
            sel_b = '0;
        end
        sel_p    = (post_row << 2) + IDX_W'(3);
    end

    // Address and data of the current write.
    always_comb begin
        if (idx_q < PRE_FIRST) begin
            wr_addr = COEF_BASE + ADDR_W'({idx_q, 2'b00});
            wr_data = idx_q[0] ? {enc_a, 16'h0000} : {enc_a, enc_b};
        end else if (idx_q < PST_FIRST) begin
            wr_addr = PRE_BASE + ADDR_W'({idx_q - PRE_FIRST, 2'b00});
            wr_data = '0;
        end else begin
            wr_addr = POST_BASE + ADDR_W'({post_row, 2'b00});
            wr_data = {{(DATA_W-POFF_W){1'b0}}, poff};
        end
    end

    assign wr_valid = busy_q;
    assign busy     = busy_q;
    assign done     = done_q;

    // R8: a stalled write keeps its address and data.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9: done lasts one cycle.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only follows an accepted write.
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));

    // R7: a start on a blocked plane leaves the port idle.
    p_blocked_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !plane_ok) |=> !wr_valid);

    // R5: pre-offset bank receives only zero.
    p_pre_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr >= PRE_BASE && wr_addr < PRE_BASE + ADDR_W'(12))
            |-> (wr_data == 32'h0));
endmodule

// File: tb/csc_coef_seq_tb.sv
// Bench: behavioural reference model (arrays and a queue of expected writes)
// compared against the port outputs on every falling clock edge.
module csc_coef_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        plane_ok = 1'b0;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic        start = 1'b0;
    logic        wr_ready = 1'b0;
    logic        wr_valid, busy, done;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] ment [12];
    logic [43:0] expq [$];       // {addr[11:0], data[31:0]}
    bit  pend_done = 0;
    bit  rdy_always = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    csc_coef_seq dut_i (
        .clk(clk), .rst_n(rst_n), .plane_ok(plane_ok),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
        .start(start), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Model of a coefficient word from the requirement arithmetic (R1-R3).
    function automatic logic [15:0] m_coef(logic [63:0] e);
        longint unsigned m = e & 64'h7FFF_FFFF_FFFF_FFFF;
        longint unsigned mt;
        int f; int code;
        if (m > 64'h3_FFFF_FFFF) m = 64'h3_FFFF_FFFF;           // R1
        if      (m < 64'h2000_0000)   begin f = 12; code = 3; end // R2
        else if (m < 64'h4000_0000)   begin f = 11; code = 2; end
        else if (m < 64'h8000_0000)   begin f = 10; code = 1; end
        else if (m < 64'h1_0000_0000) begin f = 9;  code = 0; end
        else if (m < 64'h2_0000_0000) begin f = 8;  code = 7; end
        else                          begin f = 7;  code = 6; end
        mt = (m * (64'd1 << f) + 64'h8000_0000) / 64'h1_0000_0000; // R3
        if (mt > 511) mt = 511;
        return {e[63], 3'(code), 9'(mt), 3'b000};
    endfunction

    // Model of a post-offset value (R6).
    function automatic logic [31:0] m_post(logic [63:0] e);
        longint unsigned m = (e & 64'h7FFF_FFFF_FFFF_FFFF) / 64'h10_0000;
        int v;
        if (m > 4095) m = 4095;
        v = int'(m);
        if (e[63]) v = (8192 - v) % 8192;
        return 32'(v);
    endfunction

    task automatic push_expected();
        for (int r = 0; r < 3; r++) begin
            expq.push_back({12'h100 + 12'(8*r),
                            m_coef(ment[4*r]), m_coef(ment[4*r+1])});   // R4
            expq.push_back({12'h104 + 12'(8*r), m_coef(ment[4*r+2]), 16'h0});
        end
        for (int p = 0; p < 3; p++) expq.push_back({12'h120 + 12'(4*p), 32'h0}); // R5
        for (int p = 0; p < 3; p++)
            expq.push_back({12'h130 + 12'(4*p), m_post(ment[4*p+3])});  // R6
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 done", 64'(done), 64'(pend_done));
            pend_done = 0;
            chk("R8 valid", 64'(wr_valid), 64'(expq.size() > 0));
            if (wr_valid && expq.size() > 0) begin
                chk("R4/R5/R6 addr", 64'(wr_addr), 64'(expq[0][43:32]));
                chk("R4/R5/R6 data", 64'(wr_data), 64'(expq[0][31:0]));
                if (wr_ready) begin
                    void'(expq.pop_front());
                    if (expq.size() == 0) pend_done = 1;
                end
            end
        end
    end

    // Back-pressure driver.
    always @(posedge clk) begin
        #5;
        wr_ready = rdy_always ? 1'b1 : 1'($urandom % 2);
    end

    task automatic step(); @(posedge clk); #5; endtask

    task automatic load(int i, logic [63:0] v, bit model);
        ld_valid = 1'b1; ld_idx = 4'(i); ld_data = v;
        step();
        ld_valid = 1'b0;
        if (model) ment[i] = v;
    endtask

    task automatic pulse_start(bit expect_run);
        start = 1'b1;
        step();
        start = 1'b0;
        if (expect_run) push_expected();
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && (expq.size() > 0 || pend_done); k++) step();
        repeat (3) step();
    endtask

    localparam logic [63:0] NEG = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 wr_valid", 64'(wr_valid), 0);
        chk("R10 busy", 64'(busy), 0);
        chk("R10 done", 64'(done), 0);
        step();
        plane_ok = 1'b1;
        pulse_start(0);                  // R7: nothing loaded yet
        repeat (4) step();
        // Matrix A: ranges, clamp, rounding saturation, negative zero.
        load(0, 64'h1999_999A, 1);
        load(1, NEG | 64'h3333_3333, 1);
        load(2, 64'h4CCC_CCCD, 1);
        load(3, 64'h8000_0000, 1);
        load(4, NEG | 64'hB333_3333, 1);
        load(5, 64'h1_8000_0000, 1);
        load(6, NEG | 64'h3_0000_0000, 1);
        load(7, NEG | 64'h4000_0000, 1);
        load(8, 64'h5_0000_0000, 1);
        load(9, 64'h1FFF_FFFF, 1);
        load(10, NEG, 1);
        pulse_start(0);                  // R7: entry 11 missing
        repeat (4) step();
        load(11, 64'h1_8000_0000, 1);
        plane_ok = 1'b0;
        pulse_start(0);                  // R7: plane not capable
        repeat (4) step();
        plane_ok = 1'b1;
        pulse_start(1);
        step(); step();
        pulse_start(0);                  // R9: start while busy ignored
        load(11, 64'h0, 0);              // R9: load while busy ignored
        drain();
        // Matrix B: exact range boundaries, back-to-back writes.
        rdy_always = 1;
        load(0, 64'h2000_0000, 1);
        load(1, NEG | 64'h4000_0000, 1);
        load(2, 64'h8000_0000, 1);
        load(3, NEG | 64'h2_0000_0000, 1);
        load(4, 64'h1_0000_0000, 1);
        load(5, NEG | 64'h2_0000_0000, 1);
        load(6, 64'h4_0000_0000, 1);
        load(7, 64'h0, 1);
        load(8, 64'h1FFF_FFFF, 1);
        load(9, 64'h3FFF_FFFF, 1);
        load(10, NEG | 64'h0000_0001, 1);
        load(11, NEG | 64'h0000_0FFF_FFFF, 1);
        pulse_start(1);
        drain();
        rdy_always = 0;
        pulse_start(1);                  // repeat A-free rerun with stalls
        drain();
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        finished = 1;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule